// File: doc/BRIEF.md
# Local Memory Request Router

This block sits in front of one node's local main memory in a multi-node system. Several cache clients issue word read and write requests with full system addresses. The bits above the local offset name the node that owns the word. When they name this node, the request goes to the single-ported local memory. Otherwise it is passed on, unchanged, to the port that leads into the network. Requests that the network has already delivered to this node come in on one further port. The memory treats them as one more client.

Access to the memory is shared round-robin among the cache clients and the network client, one access per cycle. A separate round-robin arbiter shares the outbound network port among the caches. Read data comes back a fixed number of cycles after the grant. It is tagged with the cache index, or it is steered to a separate network response output when the network client issued the read. A single parameter, the local address width, sets both the memory size and where the node field starts. When that width is zero the node has no memory, and every request leaves through the network. This is how a centralised shared memory is built: every node except one is configured with width zero.

All request ports follow valid/ready rules. A request moves on a clock edge where both valid and ready are high. A requester keeps valid and every request field unchanged until that edge. The outbound port raises valid without waiting for ready, and holds no request back on its own. The memory never stalls, and the response outputs have no ready.

Top module: `lmr_router`

## Requirements
- R1: A cache request whose node field `c_addr[ADDR_W-1:LOCAL_AW]` equals `NODE_ID` is carried out only on the memory port. The memory address is the low `LOCAL_AW` address bits, with the same write flag and write data.
- R2: A cache request whose node field differs from `NODE_ID` leaves only on the outbound port. Address, write flag and write data are unchanged, and `out_src` holds the cache index. Caches share the outbound port round-robin, and the cache with the lowest index comes first after reset.
- R3: At most one memory access is made per cycle. `mem_en` is high exactly in the cycles where some local request is pending, so the memory is never left idle while a local request waits.
- R4: Memory grants rotate over clients 0..N_CLI-1, with the network client as index N_CLI. The search starts just after the last granted client, and client 0 has first priority after reset. A pending local request is granted before N_CLI+1 grants to other clients have passed.
- R5: A network-inbound request is granted only through that rotation, as index N_CLI. It is addressed by `nin_addr` as a local offset.
- R6: A cache read granted in cycle t gives `rsp_valid` in cycle t+RD_LAT. In that cycle `rsp_id` holds the cache index and `rsp_data` holds the memory word as it stood before any later write. Responses come back in grant order.
- R7: A read by the network client raises `nrsp_valid` with its data RD_LAT cycles after the grant, and never `rsp_valid`.
- R8: A write gives no response on either response output.
- R9: When `out_ready` is low, no cache whose request is remote sees `c_ready`. The local grant is not affected.
- R10: With `LOCAL_AW` = 0, `mem_en` and `nin_ready` stay low and every cache request is forwarded, whatever its address.
- R11: After reset, `rsp_valid`, `nrsp_valid`, `mem_en` and `out_valid` are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_valid | input | N_CLI | Per-cache request valid |
| c_ready | output | N_CLI | Per-cache request accepted |
| c_we | input | N_CLI | Per-cache write flag |
| c_addr | input | N_CLI*ADDR_W | Packed cache addresses, cache i at bits i*ADDR_W |
| c_wdata | input | N_CLI*DATA_W | Packed cache write data |
| nin_valid | input | 1 | Network-delivered request valid |
| nin_ready | output | 1 | Network-delivered request accepted |
| nin_we | input | 1 | Network request write flag |
| nin_addr | input | max(LOCAL_AW,1) | Network request local offset |
| nin_wdata | input | DATA_W | Network request write data |
| out_valid | output | 1 | Outbound request valid |
| out_ready | input | 1 | Network accepts outbound request |
| out_we | output | 1 | Outbound write flag |
| out_addr | output | ADDR_W | Outbound full address |
| out_wdata | output | DATA_W | Outbound write data |
| out_src | output | max(clog2(N_CLI),1) | Index of forwarding cache |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write flag |
| mem_addr | output | max(LOCAL_AW,1) | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after the access |
| rsp_valid | output | 1 | Cache read response valid |
| rsp_id | output | max(clog2(N_CLI),1) | Cache index of response |
| rsp_data | output | DATA_W | Cache read data |
| nrsp_valid | output | 1 | Network read response valid |
| nrsp_data | output | DATA_W | Network read data |

## Verification
The local grant and the outbound forward are decided by two independent arbiters. Both can fire in the same cycle, and a stalled network must not disturb the local grant. Random phases mix local and remote addresses at full request rate while `out_ready` toggles. Each cycle the bench works out its own expected pick for both rotations and compares the full ready vector, the memory fields and the outbound fields. A read response leaving the pipe in the same cycle as a new grant is provoked by a saturated all-local phase. It is judged against a reference memory that is updated in grant order.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  // width of an index able to name n items (at least one bit)
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lmr_addr_dec.sv
module lmr_addr_dec #(
  parameter int ADDR_W   = 12,
  parameter int LOCAL_AW = 8,
  parameter int NODE_ID  = 3,
  localparam int NODE_W  = ADDR_W - LOCAL_AW
) (
  input  logic [NODE_W-1:0] node,
  output logic              is_local
);
  if (LOCAL_AW == 0) begin : g_no_mem
    assign is_local = 1'b0;
  end else begin : g_cmp
    assign is_local = (node == NODE_W'(NODE_ID));
  end
endmodule

// File: rtl/lmr_rr_arb.sv
module lmr_rr_arb
  import lmr_pkg::*;
#(
  parameter int N   = 4,
  localparam int IW = idx_w(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;
  logic          found;
  logic [IW-1:0] cand;

  // search starts one past the last winner
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    cand    = '0;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(last_q) + k) % N);
      if (!found && req[cand]) begin
        found        = 1'b1;
        gnt[cand]    = 1'b1;
        gnt_idx      = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             last_q <= IW'(N - 1);
    else if (take && found) last_q <= gnt_idx;
  end
endmodule

// File: rtl/lmr_rsp_pipe.sv
module lmr_rsp_pipe #(
  parameter int LAT = 2,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_v,
  input  logic           in_net,
  input  logic [IDW-1:0] in_id,
  output logic           out_v,
  output logic           out_net,
  output logic [IDW-1:0] out_id
);
  logic [LAT-1:0] v_q, net_q;
  logic [IDW-1:0] id_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      net_q <= '0;
      for (int s = 0; s < LAT; s++) id_q[s] <= '0;
    end else begin
      v_q[0]   <= in_v;
      net_q[0] <= in_net;
      id_q[0]  <= in_id;
      for (int s = 1; s < LAT; s++) begin
        v_q[s]   <= v_q[s-1];
        net_q[s] <= net_q[s-1];
        id_q[s]  <= id_q[s-1];
      end
    end
  end

  assign out_v   = v_q[LAT-1];
  assign out_net = net_q[LAT-1];
  assign out_id  = id_q[LAT-1];
endmodule

// File: rtl/lmr_router.sv
module lmr_router
  import lmr_pkg::*;
#(
  parameter int N_CLI    = 4,
  parameter int ADDR_W   = 12,
  parameter int LOCAL_AW = 8,
  parameter int NODE_ID  = 3,
  parameter int DATA_W   = 32,
  parameter int RD_LAT   = 2,
  localparam int CID_W   = idx_w(N_CLI),
  localparam int LID_W   = idx_w(N_CLI + 1),
  localparam int MA_W    = (LOCAL_AW > 0) ? LOCAL_AW : 1,
  localparam int NODE_W  = ADDR_W - LOCAL_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CLI-1:0]         c_valid,
  output logic [N_CLI-1:0]         c_ready,
  input  logic [N_CLI-1:0]         c_we,
  input  logic [N_CLI*ADDR_W-1:0]  c_addr,
  input  logic [N_CLI*DATA_W-1:0]  c_wdata,
  input  logic                     nin_valid,
  output logic                     nin_ready,
  input  logic                     nin_we,
  input  logic [MA_W-1:0]          nin_addr,
  input  logic [DATA_W-1:0]        nin_wdata,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_we,
  output logic [ADDR_W-1:0]        out_addr,
  output logic [DATA_W-1:0]        out_wdata,
  output logic [CID_W-1:0]         out_src,
  output logic                     mem_en,
  output logic                     mem_we,
  output logic [MA_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     rsp_valid,
  output logic [CID_W-1:0]         rsp_id,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     nrsp_valid,
  output logic [DATA_W-1:0]        nrsp_data
);
  localparam int  N_LOC   = N_CLI + 1;
  localparam bit  HAS_MEM = (LOCAL_AW > 0);

  logic [N_CLI-1:0] is_loc, rem_req, rem_gnt;
  logic [N_LOC-1:0] loc_req, loc_gnt;
  logic [LID_W-1:0] loc_idx;
  logic [CID_W-1:0] rem_idx;
  logic             p_v, p_net;
  logic [CID_W-1:0] p_id;

  // node-field decode per cache
  for (genvar i = 0; i < N_CLI; i++) begin : g_dec
    lmr_addr_dec #(.ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW), .NODE_ID(NODE_ID)) u_dec (
      .node     (c_addr[i*ADDR_W+LOCAL_AW +: NODE_W]),
      .is_local (is_loc[i])
    );
  end

  assign loc_req = {nin_valid & HAS_MEM, c_valid & is_loc};
  assign rem_req = c_valid & ~is_loc;

  // memory side: network client sits at index N_CLI
  lmr_rr_arb #(.N(N_LOC)) u_loc_arb (
    .clk, .rst_n, .req(loc_req), .take(1'b1), .gnt(loc_gnt), .gnt_idx(loc_idx)
  );

  lmr_rr_arb #(.N(N_CLI)) u_rem_arb (
    .clk, .rst_n, .req(rem_req), .take(out_ready), .gnt(rem_gnt), .gnt_idx(rem_idx)
  );

  assign c_ready   = loc_gnt[N_CLI-1:0] | (rem_gnt & {N_CLI{out_ready}});
  assign nin_ready = loc_gnt[N_CLI];
  assign mem_en    = |loc_req;

  if (HAS_MEM) begin : g_mem_mux
    always_comb begin
      mem_we    = nin_we;
      mem_wdata = nin_wdata;
      mem_addr  = nin_addr;
      for (int i = 0; i < N_CLI; i++) begin
        if (loc_gnt[i]) begin
          mem_we    = c_we[i];
          mem_wdata = c_wdata[i*DATA_W +: DATA_W];
          mem_addr  = c_addr[i*ADDR_W +: MA_W];
        end
      end
    end
  end else begin : g_no_mem
    assign mem_we    = 1'b0;
    assign mem_wdata = '0;
    assign mem_addr  = '0;
  end

  always_comb begin
    out_we    = 1'b0;
    out_addr  = '0;
    out_wdata = '0;
    for (int i = 0; i < N_CLI; i++) begin
      if (rem_gnt[i]) begin
        out_we    = c_we[i];
        out_addr  = c_addr[i*ADDR_W +: ADDR_W];
        out_wdata = c_wdata[i*DATA_W +: DATA_W];
      end
    end
  end

  assign out_valid = |rem_req;
  assign out_src   = rem_idx;

  // read tags travel alongside the memory latency
  lmr_rsp_pipe #(.LAT(RD_LAT), .IDW(CID_W)) u_pipe (
    .clk, .rst_n,
    .in_v    (mem_en & ~mem_we),
    .in_net  (loc_gnt[N_CLI]),
    .in_id   (CID_W'(loc_idx)),
    .out_v   (p_v),
    .out_net (p_net),
    .out_id  (p_id)
  );

  assign rsp_valid  = p_v & ~p_net;
  assign nrsp_valid = p_v & p_net;
  assign rsp_id     = p_id;
  assign rsp_data   = mem_rdata;
  assign nrsp_data  = mem_rdata;
endmodule

// File: rtl/lmr_router_chk.sv
module lmr_router_chk
  import lmr_pkg::*;
#(
  parameter int N_CLI    = 4,
  parameter int ADDR_W   = 12,
  parameter int LOCAL_AW = 8,
  parameter int NODE_ID  = 3,
  parameter int RD_LAT   = 2,
  localparam int CID_W   = idx_w(N_CLI),
  localparam int MA_W    = (LOCAL_AW > 0) ? LOCAL_AW : 1,
  localparam int NODE_W  = ADDR_W - LOCAL_AW
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CLI-1:0]        c_valid,
  input logic [N_CLI-1:0]        c_ready,
  input logic [N_CLI*ADDR_W-1:0] c_addr,
  input logic                    nin_valid,
  input logic                    nin_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [ADDR_W-1:0]       out_addr,
  input logic [CID_W-1:0]        out_src,
  input logic                    mem_en,
  input logic                    mem_we,
  input logic [MA_W-1:0]         mem_addr,
  input logic                    rsp_valid,
  input logic                    nrsp_valid
);
  logic [N_CLI-1:0]  loc;
  logic [RD_LAT-1:0] rd_hist;

  if (LOCAL_AW > 0) begin : g_loc
    for (genvar i = 0; i < N_CLI; i++) begin : g_cl
      assign loc[i] = (c_addr[i*ADDR_W+LOCAL_AW +: NODE_W] == NODE_W'(NODE_ID));
    end
  end else begin : g_noloc
    assign loc = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_hist <= '0;
    else        rd_hist <= (rd_hist << 1) | RD_LAT'(mem_en && !mem_we);
  end

  for (genvar i = 0; i < N_CLI; i++) begin : g_per
    // R1
    a_r1_local_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid[i] && c_ready[i] && loc[i]) |-> (mem_en && mem_addr == c_addr[i*ADDR_W +: MA_W]));
    // R2
    a_r2_remote_out: assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid[i] && c_ready[i] && !loc[i]) |->
        (out_valid && out_ready && out_src == CID_W'(i) && out_addr == c_addr[i*ADDR_W +: ADDR_W]));
    // R9
    a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_ready && c_valid[i] && !loc[i]) |-> !c_ready[i]);
  end

  a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c_valid & c_ready & loc, nin_valid & nin_ready}));

  a_r3_en_matches: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en == (|{c_valid & c_ready & loc, nin_valid & nin_ready}));

  a_r5_net_via_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (nin_valid && nin_ready) |-> (mem_en && !(|(c_valid & c_ready & loc))));

  a_r6_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || nrsp_valid) == rd_hist[RD_LAT-1]);

  a_r7_rsp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && nrsp_valid));

  if (LOCAL_AW == 0) begin : g_r10
    a_r10_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en && !nin_ready);
  end
endmodule

bind lmr_router lmr_router_chk #(
  .N_CLI(N_CLI), .ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW), .NODE_ID(NODE_ID), .RD_LAT(RD_LAT)
) u_chk (.*);

// File: tb/tb_lmr_router.sv
module tb_lmr_router;
  localparam int N = 3, AW = 8, LAW = 4, NID = 5, DW = 16, LAT = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic [N-1:0]    c_valid, c_ready, c_we;
  logic [N*AW-1:0] c_addr;
  logic [N*DW-1:0] c_wdata;
  logic nin_valid, nin_ready, nin_we;
  logic [LAW-1:0] nin_addr;
  logic [DW-1:0]  nin_wdata;
  logic out_valid, out_ready, out_we;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_wdata;
  logic [1:0]    out_src, rsp_id;
  logic mem_en, mem_we, rsp_valid, nrsp_valid;
  logic [LAW-1:0] mem_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata, rsp_data, nrsp_data;

  lmr_router #(.N_CLI(N), .ADDR_W(AW), .LOCAL_AW(LAW), .NODE_ID(NID),
               .DATA_W(DW), .RD_LAT(LAT)) dut (
    .clk, .rst_n, .c_valid, .c_ready, .c_we, .c_addr, .c_wdata,
    .nin_valid, .nin_ready, .nin_we, .nin_addr, .nin_wdata,
    .out_valid, .out_ready, .out_we, .out_addr, .out_wdata, .out_src,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .rsp_valid, .rsp_id, .rsp_data, .nrsp_valid, .nrsp_data
  );

  // node with no local memory
  logic [1:0]  z_cv, z_crdy, z_cwe;
  logic [15:0] z_caddr;
  logic [31:0] z_cwd;
  logic z_nv, z_nrdy, z_ovalid, z_ordy, z_owe, z_men, z_mwe, z_rv, z_nrv;
  logic [0:0] z_naddr, z_osrc, z_maddr, z_rid;
  logic [7:0] z_oaddr;
  logic [15:0] z_nwd, z_owd, z_mwd, z_rd, z_nrd;

  lmr_router #(.N_CLI(2), .ADDR_W(8), .LOCAL_AW(0), .NODE_ID(0),
               .DATA_W(16), .RD_LAT(LAT)) dut0 (
    .clk, .rst_n, .c_valid(z_cv), .c_ready(z_crdy), .c_we(z_cwe), .c_addr(z_caddr),
    .c_wdata(z_cwd), .nin_valid(z_nv), .nin_ready(z_nrdy), .nin_we(1'b0),
    .nin_addr(z_naddr), .nin_wdata(z_nwd), .out_valid(z_ovalid), .out_ready(z_ordy),
    .out_we(z_owe), .out_addr(z_oaddr), .out_wdata(z_owd), .out_src(z_osrc),
    .mem_en(z_men), .mem_we(z_mwe), .mem_addr(z_maddr), .mem_wdata(z_mwd),
    .mem_rdata(16'h0), .rsp_valid(z_rv), .rsp_id(z_rid), .rsp_data(z_rd),
    .nrsp_valid(z_nrv), .nrsp_data(z_nrd)
  );

  // memory model with LAT-cycle read pipeline
  logic [DW-1:0] mm [16];
  logic [DW-1:0] rdp [LAT];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) mm[k] <= DW'(k * 613 + 7);
    end else if (mem_en && mem_we) begin
      mm[mem_addr] <= mem_wdata;
    end
    rdp[0] <= mm[mem_addr];
    for (int s = 1; s < LAT; s++) rdp[s] <= rdp[s-1];
  end
  assign mem_rdata = rdp[LAT-1];

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;
  int p_req, p_loc, p_we, p_rdy, p_net;
  int lptr, rptr;
  logic [DW-1:0] refm [16];
  bit ev [LAT]; bit enet [LAT]; bit ewr [LAT];
  int eid [LAT];
  logic [DW-1:0] edat [LAT];
  int waitc [N+1];
  bit done [N+1];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic roll(output int r, input int m);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = int'(seed % 32'(m));
  endtask

  function automatic int pick(input logic [7:0] rq, input int last, input int n);
    for (int k = 1; k <= n; k++) begin
      if (rq[(last + k) % n]) return (last + k) % n;
    end
    return -1;
  endfunction

  task automatic drive();
    int r, nd, off;
    for (int i = 0; i < N; i++) begin
      if (done[i]) c_valid[i] = 1'b0;
      done[i] = 0;
      roll(r, 100);
      if (!c_valid[i] && r < p_req) begin
        roll(r, 100);
        if (r < p_loc) nd = NID;
        else begin roll(nd, 16); if (nd == NID) nd = nd ^ 1; end
        roll(off, 16);
        c_addr[i*AW +: AW] = {4'(nd), 4'(off)};
        roll(r, 100); c_we[i] = (r < p_we);
        roll(r, 65536); c_wdata[i*DW +: DW] = DW'(r);
        c_valid[i] = 1'b1;
      end
    end
    if (done[N]) nin_valid = 1'b0;
    done[N] = 0;
    roll(r, 100);
    if (!nin_valid && r < p_net) begin
      roll(off, 16); nin_addr = 4'(off);
      roll(r, 100); nin_we = (r < p_we);
      roll(r, 65536); nin_wdata = DW'(r);
      nin_valid = 1'b1;
    end
    roll(r, 100);
    out_ready = (r < p_rdy);
  endtask

  task automatic check_cycle();
    logic [7:0] lr, rr, erdy;
    int lg, rg;
    logic [3:0] ea;
    logic ewe;
    logic [DW-1:0] ewd;
    string t;
    lr = '0; rr = '0;
    for (int i = 0; i < N; i++) begin
      if (c_valid[i]) begin
        if (c_addr[i*AW+LAW +: 4] == 4'(NID)) lr[i] = 1'b1;
        else rr[i] = 1'b1;
      end
    end
    lr[N] = nin_valid;
    lg = pick(lr, lptr, N + 1);
    rg = pick(rr, rptr, N);
    erdy = '0;
    if (lg >= 0) erdy[lg] = 1'b1;
    if (rg >= 0 && out_ready) erdy[rg] = 1'b1;
    t = (!out_ready && rr != 0) ? "R9 stalled remote" : "R4 rotation";
    chk({nin_ready, c_ready} == erdy[N:0], t, 64'({nin_ready, c_ready}), 64'(erdy[N:0]));
    chk(mem_en == (lg >= 0), "R3 mem_en", 64'(mem_en), 64'(lg >= 0));
    ea = '0; ewe = 1'b0; ewd = '0;
    if (lg >= 0) begin
      if (lg == N) begin ea = nin_addr; ewe = nin_we; ewd = nin_wdata; end
      else begin
        ea = c_addr[lg*AW +: 4]; ewe = c_we[lg]; ewd = c_wdata[lg*DW +: DW];
      end
      chk(mem_addr == ea && mem_we == ewe && (!ewe || mem_wdata == ewd),
          (lg == N) ? "R5 net access" : "R1 local access",
          64'({mem_we, mem_addr, mem_wdata}), 64'({ewe, ea, ewd}));
    end
    chk(out_valid == (rg >= 0), "R2 out_valid", 64'(out_valid), 64'(rg >= 0));
    if (rg >= 0)
      chk(out_addr == c_addr[rg*AW +: AW] && out_we == c_we[rg] &&
          out_wdata == c_wdata[rg*DW +: DW] && out_src == 2'(rg), "R2 forward",
          64'({out_src, out_addr}), 64'({2'(rg), c_addr[rg*AW +: AW]}));
    if (ev[LAT-1]) begin
      if (enet[LAT-1])
        chk(nrsp_valid && !rsp_valid && nrsp_data == edat[LAT-1], "R7 net response",
            64'({nrsp_valid, nrsp_data}), 64'({1'b1, edat[LAT-1]}));
      else
        chk(rsp_valid && !nrsp_valid && rsp_id == 2'(eid[LAT-1]) && rsp_data == edat[LAT-1],
            "R6 cache response", 64'({rsp_valid, rsp_id, rsp_data}),
            64'({1'b1, 2'(eid[LAT-1]), edat[LAT-1]}));
    end else begin
      chk(!rsp_valid && !nrsp_valid, ewr[LAT-1] ? "R8 write silent" : "R6 idle",
          64'({rsp_valid, nrsp_valid}), 64'(0));
    end
    for (int j = 0; j <= N; j++) begin
      if (lr[j]) begin
        if (j == lg) begin
          chk(waitc[j] <= N, "R4 bounded wait", 64'(waitc[j]), 64'(N));
          waitc[j] = 0;
        end else if (lg >= 0) waitc[j]++;
      end
    end
    for (int s = LAT - 1; s > 0; s--) begin
      ev[s] = ev[s-1]; enet[s] = enet[s-1]; ewr[s] = ewr[s-1];
      eid[s] = eid[s-1]; edat[s] = edat[s-1];
    end
    ev[0] = (lg >= 0) && !ewe; enet[0] = (lg == N); ewr[0] = (lg >= 0) && ewe;
    eid[0] = lg; edat[0] = refm[ea];
    if (lg >= 0) begin
      if (ewe) refm[ea] = ewd;
      lptr = lg; done[lg] = 1;
    end
    if (rg >= 0 && out_ready) begin rptr = rg; done[rg] = 1; end
  endtask

  task automatic step();
    @(negedge clk);
    drive();
    #4;
    check_cycle();
  endtask

  task automatic phase(input int pr, input int pl, input int pw, input int py, input int pn, input int cyc);
    p_req = pr; p_loc = pl; p_we = pw; p_rdy = py; p_net = pn;
    repeat (cyc) step();
  endtask

  initial begin
    rst_n = 1'b0;
    c_valid = '0; c_we = '0; c_addr = '0; c_wdata = '0;
    nin_valid = 1'b0; nin_we = 1'b0; nin_addr = '0; nin_wdata = '0;
    out_ready = 1'b0;
    z_cv = '0; z_cwe = '0; z_caddr = '0; z_cwd = '0; z_nv = 1'b0; z_naddr = '0;
    z_nwd = '0; z_ordy = 1'b0;
    lptr = N; rptr = N - 1;
    for (int k = 0; k < 16; k++) refm[k] = DW'(k * 613 + 7);
    for (int s = 0; s < LAT; s++) begin ev[s] = 0; enet[s] = 0; ewr[s] = 0; eid[s] = 0; edat[s] = '0; end
    for (int j = 0; j <= N; j++) begin waitc[j] = 0; done[j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #4;
    // R11 reset state
    chk(!rsp_valid && !nrsp_valid && !mem_en && !out_valid, "R11 reset state",
        64'({rsp_valid, nrsp_valid, mem_en, out_valid}), 64'(0));
    phase(60, 50, 40, 70, 40, 2500);   // mixed traffic
    phase(100, 100, 30, 100, 100, 600); // saturated local, R4 wait bound
    phase(100, 0, 40, 50, 0, 400);      // remote only under stall, R9
    phase(100, 50, 40, 100, 60, 400);   // grant and forward in one cycle
    phase(0, 50, 40, 100, 0, 30);       // drain
    // R10: node without memory
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      z_cv = 2'b11; z_caddr = {8'h03, 8'h0a}; z_nv = 1'b1; z_ordy = 1'b1;
      #4;
      chk(!z_men && !z_nrdy, "R10 no memory", 64'({z_men, z_nrdy}), 64'(0));
      chk(z_ovalid && z_crdy == ((k % 2 == 0) ? 2'b01 : 2'b10), "R10 all forwarded",
          64'({z_ovalid, z_crdy}), 64'({1'b1, (k % 2 == 0) ? 2'b01 : 2'b10}));
      chk(z_oaddr == ((k % 2 == 0) ? 8'h0a : 8'h03), "R10 forward addr",
          64'(z_oaddr), 64'((k % 2 == 0) ? 8'h0a : 8'h03));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule